// File: doc/BRIEF.md
# Scissor Clip and Frame-Buffer Wrap Stage

This stage sits in the pixel path just before frame-buffer writes. Each cycle it can accept one screen coordinate. That coordinate already carries the fixed bias of 342 that software adds on both axes. The stage checks the coordinate against an inclusive clip rectangle. It then shifts the coordinate by a programmable per-axis offset and reduces the result modulo 1024 on each axis. The last test is whether the wrapped point falls inside the 640 x 528 frame buffer. The outputs are a write strobe and the frame-buffer column and row, and they appear one clock after the input.

The offset is stored at half its value and still includes the bias. The wrap is done independently for every pixel. Two effects follow. A pixel that lies inside the clip rectangle can still be dropped because its wrapped position is off-screen. Two pixels that are 1024 apart can also land on the same frame-buffer location.

Three configuration words are loaded through a plain write port: the low corner, the high corner and the shift.

Top module: `scissor_wrap`

## Requirements
- R1: A write to address 0x20 loads the left bound from data bits 22..12 and the top bound from data bits 10..0. A write to address 0x21 loads the right bound from bits 22..12 and the bottom bound from bits 10..0. All four bounds are 11-bit unsigned values.
- R2: A write to address 0x59 loads the X half-offset from data bits 9..0 and the Y half-offset from data bits 19..10.
- R3: A write to any other address changes no configuration, and neither do data bits outside the fields named in R1 and R2.
- R4: A pixel passes the clip test only when left <= x <= right and top <= y <= bottom. All four comparisons are inclusive.
- R5: The frame-buffer column is (x - 2*xhalf) mod 1024 and the frame-buffer row is (y - 2*yhalf) mod 1024. Both are reported on every valid output, whether or not the write strobe is set.
- R6: The write strobe is 1 only when the pixel passes the clip test, the column is below 640 and the row is below 528.
- R7: out_valid equals in_valid delayed by exactly one clock. out_we is 0 whenever out_valid is 0.
- R8: Synchronous active-high reset clears out_valid and sets all bounds and half-offsets to zero. After reset, pixel (0,0) is therefore written to frame-buffer (0,0).
- R9: A configuration write presented in the same cycle as a pixel does not affect that pixel. It applies from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration word address |
| cfg_data | input | 23 | Configuration payload (bits 22..0) |
| in_valid | input | 1 | Pixel coordinate valid |
| in_x | input | 11 | Biased pixel X |
| in_y | input | 11 | Biased pixel Y |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_we | output | 1 | Frame-buffer write strobe |
| out_fb_x | output | 10 | Wrapped frame-buffer column |
| out_fb_y | output | 10 | Wrapped frame-buffer row |

## Verification
Several properties are checked on every cycle:
- the one-cycle valid latency;
- that a write strobe only comes with a valid output;
- that a strobed position always lies inside the frame buffer;
- that a strobed pixel lay inside the clip rectangle that was loaded when it arrived;
- that writes to unmapped addresses leave the configuration untouched.

Other behaviours can only be shown by the bench's scenarios against its reference model:
- the exact wrapped coordinates;
- the field positions inside each word;
- pixels that pass the clip test and are still dropped;
- two pixels 1024 apart aliasing onto one location;
- the boundary pixels on each inclusive edge;
- the same-cycle ordering of a configuration write against a pixel.

// File: rtl/scissor_wrap_pkg.sv
package scissor_wrap_pkg;

    localparam int COORD_W = 11;
    localparam int FB_AW   = 10;
    localparam int OFF_W   = 10;
    localparam int REG_AW  = 8;
    localparam int REG_DW  = 23;

    localparam logic [REG_AW-1:0] ADDR_CLIP_LO = 8'h20;
    localparam logic [REG_AW-1:0] ADDR_CLIP_HI = 8'h21;
    localparam logic [REG_AW-1:0] ADDR_SHIFT   = 8'h59;

    localparam int HORIZ_LSB = 12;
    localparam int VERT_LSB  = 0;
    localparam int OFFX_LSB  = 0;
    localparam int OFFY_LSB  = 10;

    typedef logic [COORD_W-1:0] coord_t;
    typedef logic [FB_AW-1:0]   fbpos_t;
    typedef logic [OFF_W-1:0]   half_off_t;

    typedef struct packed {
        coord_t    lo_x;
        coord_t    lo_y;
        coord_t    hi_x;
        coord_t    hi_y;
        half_off_t off_x;
        half_off_t off_y;
    } clip_cfg_t;

    typedef struct packed {
        logic   valid;
        logic   we;
        fbpos_t x;
        fbpos_t y;
    } fb_wr_t;

    // Subtract twice the half-offset, keep the low bits: modulo-1024 wrap.
    function automatic fbpos_t wrap_shift(input coord_t pos, input half_off_t half);
        coord_t dbl;
        dbl = {half, 1'b0};
        return fbpos_t'(pos - dbl);
    endfunction

endpackage

// File: rtl/scissor_cfg_regs.sv
module scissor_cfg_regs
    import scissor_wrap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [REG_DW-1:0] cfg_data,
    output clip_cfg_t         cfg
);

    clip_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                ADDR_CLIP_LO: begin
                    cfg_q.lo_x <= cfg_data[HORIZ_LSB +: COORD_W];
                    cfg_q.lo_y <= cfg_data[VERT_LSB  +: COORD_W];
                end
                ADDR_CLIP_HI: begin
                    cfg_q.hi_x <= cfg_data[HORIZ_LSB +: COORD_W];
                    cfg_q.hi_y <= cfg_data[VERT_LSB  +: COORD_W];
                end
                ADDR_SHIFT: begin
                    cfg_q.off_x <= cfg_data[OFFX_LSB +: OFF_W];
                    cfg_q.off_y <= cfg_data[OFFY_LSB +: OFF_W];
                end
                default: ;
            endcase
        end
    end

    assign cfg = cfg_q;

    // R3: an unmapped address leaves every field as it was
    a_r3_unmapped_stable: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr != ADDR_CLIP_LO && cfg_addr != ADDR_CLIP_HI &&
         cfg_addr != ADDR_SHIFT) |=> $stable(cfg_q))
        else $error("a_r3_unmapped_stable");

endmodule

// File: rtl/scissor_axis.sv
module scissor_axis
    import scissor_wrap_pkg::*;
#(
    parameter int unsigned LIMIT = 640
)(
    input  coord_t    pos,
    input  coord_t    lo,
    input  coord_t    hi,
    input  half_off_t half,
    output logic      in_box,
    output fbpos_t    fb_pos,
    output logic      in_fb
);

    localparam logic [FB_AW:0] LIM = (FB_AW+1)'(LIMIT);

    always_comb begin
        in_box = (pos >= lo) && (pos <= hi);
        fb_pos = wrap_shift(pos, half);
        in_fb  = {1'b0, fb_pos} < LIM;
    end

endmodule

// File: rtl/scissor_wrap.sv
module scissor_wrap
    import scissor_wrap_pkg::*;
#(
    parameter int unsigned FB_W = 640,
    parameter int unsigned FB_H = 528
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [REG_AW-1:0]   cfg_addr,
    input  logic [REG_DW-1:0]   cfg_data,
    input  logic                in_valid,
    input  logic [COORD_W-1:0]  in_x,
    input  logic [COORD_W-1:0]  in_y,
    output logic                out_valid,
    output logic                out_we,
    output logic [FB_AW-1:0]    out_fb_x,
    output logic [FB_AW-1:0]    out_fb_y
);

    localparam int NAXES = 2;
    localparam logic [FB_AW:0] LIM_X = (FB_AW+1)'(FB_W);
    localparam logic [FB_AW:0] LIM_Y = (FB_AW+1)'(FB_H);

    clip_cfg_t cfg_q;

    scissor_cfg_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .cfg      (cfg_q)
    );

    coord_t    ax_pos  [NAXES];
    coord_t    ax_lo   [NAXES];
    coord_t    ax_hi   [NAXES];
    half_off_t ax_half [NAXES];
    logic      ax_box  [NAXES];
    fbpos_t    ax_fb   [NAXES];
    logic      ax_in   [NAXES];

    always_comb begin
        ax_pos[0]  = in_x;       ax_pos[1]  = in_y;
        ax_lo[0]   = cfg_q.lo_x; ax_lo[1]   = cfg_q.lo_y;
        ax_hi[0]   = cfg_q.hi_x; ax_hi[1]   = cfg_q.hi_y;
        ax_half[0] = cfg_q.off_x; ax_half[1] = cfg_q.off_y;
    end

    for (genvar g = 0; g < NAXES; g++) begin : g_axis
        scissor_axis #(
            .LIMIT ((g == 0) ? FB_W : FB_H)
        ) u_axis (
            .pos    (ax_pos[g]),
            .lo     (ax_lo[g]),
            .hi     (ax_hi[g]),
            .half   (ax_half[g]),
            .in_box (ax_box[g]),
            .fb_pos (ax_fb[g]),
            .in_fb  (ax_in[g])
        );
    end

    fb_wr_t out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.valid <= in_valid;
            out_q.we    <= in_valid & ax_box[0] & ax_box[1] & ax_in[0] & ax_in[1];
            out_q.x     <= ax_fb[0];
            out_q.y     <= ax_fb[1];
        end
    end

    assign out_valid = out_q.valid;
    assign out_we    = out_q.we;
    assign out_fb_x  = out_q.x;
    assign out_fb_y  = out_q.y;

    // Arms the history-based checks once a full cycle out of reset has passed.
    logic chk_armed_q;
    always_ff @(posedge clk) begin
        if (rst) chk_armed_q <= 1'b0;
        else     chk_armed_q <= 1'b1;
    end

    // R7: one-cycle latency on valid
    a_r7_valid_latency: assert property (@(posedge clk) disable iff (rst)
        chk_armed_q |-> (out_valid == $past(in_valid)))
        else $error("a_r7_valid_latency");

    // R7: no strobe without a valid result
    a_r7_we_needs_valid: assert property (@(posedge clk) disable iff (rst)
        out_we |-> out_valid)
        else $error("a_r7_we_needs_valid");

    // R6: a strobed position is always on-screen
    a_r6_we_on_screen: assert property (@(posedge clk) disable iff (rst)
        out_we |-> (({1'b0, out_fb_x} < LIM_X) && ({1'b0, out_fb_y} < LIM_Y)))
        else $error("a_r6_we_on_screen");

    // R4: a strobed pixel was inside the clip box loaded when it arrived
    a_r4_we_inside_box: assert property (@(posedge clk) disable iff (rst)
        (chk_armed_q && out_we) |->
            ($past(in_x) >= $past(cfg_q.lo_x) && $past(in_x) <= $past(cfg_q.hi_x) &&
             $past(in_y) >= $past(cfg_q.lo_y) && $past(in_y) <= $past(cfg_q.hi_y)))
        else $error("a_r4_we_inside_box");

endmodule

// File: tb/scissor_wrap_tb_top.sv
module scissor_wrap_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [22:0] cfg_data = '0;
    logic        in_valid = 1'b0;
    logic [10:0] in_x = '0;
    logic [10:0] in_y = '0;
    logic        out_valid;
    logic        out_we;
    logic [9:0]  out_fb_x;
    logic [9:0]  out_fb_y;

    always #5 clk = ~clk;

    scissor_wrap dut_i (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
        .out_valid(out_valid), .out_we(out_we),
        .out_fb_x(out_fb_x), .out_fb_y(out_fb_y)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference model state
    int m_lx = 0, m_ly = 0, m_hx = 0, m_hy = 0, m_ox = 0, m_oy = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int wrap_ref(input int p, input int half);
        return (((p - 2 * half) % 1024) + 1024) % 1024;
    endfunction

    function automatic bit we_ref(input int x, input int y);
        bit box;
        box = (x >= m_lx) && (x <= m_hx) && (y >= m_ly) && (y <= m_hy);
        return box && (wrap_ref(x, m_ox) < 640) && (wrap_ref(y, m_oy) < 528);
    endfunction

    function automatic void model_write(input int a, input int d);
        if (a == 'h20) begin m_lx = (d >> 12) & 'h7ff; m_ly = d & 'h7ff; end
        else if (a == 'h21) begin m_hx = (d >> 12) & 'h7ff; m_hy = d & 'h7ff; end
        else if (a == 'h59) begin m_ox = d & 'h3ff; m_oy = (d >> 10) & 'h3ff; end
    endfunction

    function automatic int pack2(input int hi, input int lo);
        return ((hi & 'h7ff) << 12) | (lo & 'h7ff);
    endfunction

    function automatic int packoff(input int ox, input int oy);
        return ((oy & 'h3ff) << 10) | (ox & 'h3ff);
    endfunction

    // called at a negedge; returns at a negedge
    task automatic cfg_wr(input int a, input int d);
        cfg_we = 1'b1; cfg_addr = a[7:0]; cfg_data = d[22:0];
        @(negedge clk);
        cfg_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic check_out(input string req, input bit ewe, input int ex, input int ey);
        chk(out_valid == 1'b1, req, out_valid, 1);
        chk(out_we == ewe, req, out_we, ewe);
        chk(out_fb_x == ex[9:0], req, out_fb_x, ex);
        chk(out_fb_y == ey[9:0], req, out_fb_y, ey);
    endtask

    task automatic px(input int x, input int y, input string req);
        bit ewe; int ex, ey;
        ewe = we_ref(x, y); ex = wrap_ref(x, m_ox); ey = wrap_ref(y, m_oy);
        in_valid = 1'b1; in_x = x[10:0]; in_y = y[10:0];
        @(negedge clk);
        in_valid = 1'b0;
        check_out(req, ewe, ex, ey);
    endtask

    // expects a specific strobe and column, as a directed check
    task automatic px_exp(input int x, input int y, input bit ewe, input int ex, input string req);
        in_valid = 1'b1; in_x = x[10:0]; in_y = y[10:0];
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_we == ewe, req, out_we, ewe);
        chk(out_fb_x == ex[9:0], req, out_fb_x, ex);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0123));
        repeat (3) @(negedge clk);
        // R8: reset clears the output
        chk(out_valid == 1'b0, "R8 reset valid", out_valid, 0);
        chk(out_we == 1'b0, "R8 reset we", out_we, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R8 idle after reset", out_valid, 0);
        // R8: zeroed config passes (0,0) to (0,0), rejects (1,0)
        px_exp(0, 0, 1'b1, 0, "R8 zero config origin");
        px_exp(1, 0, 1'b0, 1, "R8 zero config outside");
        // R7: no input, no output
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 idle valid", out_valid, 0);
        chk(out_we == 1'b0, "R7 idle we", out_we, 0);

        // R1 R2: full-screen biased setup, unused bits set to catch misplaced fields
        cfg_wr('h20, pack2(342, 342) | (1 << 11));
        cfg_wr('h21, pack2(981, 869) | (1 << 11));
        cfg_wr('h59, packoff(171, 171) | (7 << 20));
        px_exp(342, 342, 1'b1, 0, "R1 R2 origin");
        px(981, 869, "R1 R2 far corner");
        // R4: inclusive edges
        px_exp(341, 400, 1'b0, 1023, "R4 left-1");
        px_exp(342, 400, 1'b1, 0, "R4 left");
        px_exp(981, 400, 1'b1, 639, "R4 right");
        px_exp(982, 400, 1'b0, 640, "R4 right+1");
        px(500, 341, "R4 top-1");
        px(500, 342, "R4 top");
        px(500, 869, "R4 bottom");
        px(500, 870, "R4 bottom+1");

        // R5 R6: shift of 2 -> clip pass but dropped, and shifted lands
        cfg_wr('h59, packoff(172, 171));
        px_exp(342, 400, 1'b0, 1022, "R6 passes clip but dropped");
        px_exp(344, 400, 1'b1, 0, "R5 shift2 x2");
        px_exp(981, 400, 1'b1, 637, "R5 shift2 x639");
        // R5: shift of 510 wraps to both sides
        cfg_wr('h59, packoff(426, 171));
        px_exp(852, 400, 1'b1, 0, "R5 shift510 x510");
        px_exp(981, 400, 1'b1, 129, "R5 shift510 x639");
        px_exp(342, 400, 1'b1, 514, "R5 shift510 x0");
        px_exp(467, 400, 1'b1, 639, "R5 shift510 x125");
        // R5: aliasing 1024 apart
        cfg_wr('h21, pack2(2005, 869));
        cfg_wr('h59, packoff(171, 171));
        px_exp(342, 400, 1'b1, 0, "R5 alias x0");
        px_exp(1366, 400, 1'b1, 0, "R5 alias x1024");
        // R6: row limit 528
        px(500, 342 + 527, "R6 row 527");
        cfg_wr('h21, pack2(2005, 2047));
        px(500, 342 + 528, "R6 row 528 dropped");

        // R3: unmapped address and stray bits change nothing
        cfg_wr('h22, 23'h7fffff);
        cfg_wr('h58, 0);
        px_exp(342, 400, 1'b1, 0, "R3 unmapped ignored");
        px(2047, 2047, "R3 unmapped ignored hi");

        // R9: write in same cycle as pixel uses old config
        begin
            int oldx;
            oldx = wrap_ref(600, m_ox);
            cfg_we = 1'b1; cfg_addr = 8'h59; cfg_data = 23'(packoff(0, 171));
            in_valid = 1'b1; in_x = 11'd600; in_y = 11'd400;
            @(negedge clk);
            cfg_we = 1'b0; in_valid = 1'b0;
            chk(out_fb_x == oldx[9:0], "R9 same-cycle old config", out_fb_x, oldx);
            model_write('h59, packoff(0, 171));
            px_exp(600, 400, 1'b1, 600, "R9 next cycle new config");
        end

        // random mix
        for (int r = 0; r < 12; r++) begin
            int lx, hx, ly, hy;
            lx = $urandom % 1400; hx = lx + ($urandom % (2048 - lx));
            ly = $urandom % 1400; hy = ly + ($urandom % (2048 - ly));
            cfg_wr('h20, pack2(lx, ly) | ($urandom & (1 << 11)));
            cfg_wr('h21, pack2(hx, hy));
            cfg_wr('h59, packoff($urandom, $urandom) | (($urandom & 7) << 20));
            if ($urandom % 2) cfg_wr('h10 + ($urandom % 16), $urandom);
            for (int k = 0; k < 150; k++) begin
                int x, y;
                x = (k % 2) ? ($urandom % 2048) : (lx + ($urandom % (hx - lx + 1)));
                y = (k % 2) ? ($urandom % 2048) : (ly + ($urandom % (hy - ly + 1)));
                px(x, y, "R4 R5 R6 random");
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule